// File: doc/BRIEF.md
# Debug Management Interrupt Router

This block decides what happens to each debug-related event seen by a processor core. A 64-bit control word, written and read over a simple synchronous register port, selects which event sources may raise a debug management interrupt. A stall option turns any such request into a core stall request instead. Sources that are not routed as interrupts go out unchanged as ordinary debug exceptions. The event sources are instruction retirement (single stepping), the ICEBP opcode (F1), ordinary debug exceptions, task-switch debug faults and an external debug pin.

Once an interrupt is raised, the block enters debug mode on the next clock and stays there until the handler issues a resume strobe. No further interrupt or stall is requested while in debug mode. In that mode the block can enable the suspend output. On entry it can also request that the cache-disable and no-write-through bits be set. All event inputs are single-cycle pulses, and the request outputs respond to them combinationally in the same cycle. There is no data stream, so every pin is a plain level or pulse with no back-pressure.

Top module: `dbg_route_top`

## Requirements
- R1: After reset the control word reads as zero, the block is not in debug mode, and every request output is low.
- R2: A write with `cfg_sel_i` and `cfg_we_i` high stores all 64 bits, including the reserved bits 63:10 and 1:0. A read with `cfg_sel_i` high and `cfg_we_i` low returns the stored word on `cfg_rdata_o` one clock later.
- R3: With bit 9 (step) set and bit 8 (stall) clear, a `retire_i` pulse outside debug mode raises `dmi_req_o` in the same cycle.
- R4: With bits 9 and 8 both set, a `retire_i` pulse raises `stall_req_o` instead of `dmi_req_o`, and debug mode is not entered.
- R5: With bit 8 set, every other enabled source also raises `stall_req_o` rather than `dmi_req_o`, and that source produces no exception pass-through.
- R6: `dmi_req_o` sets `dbg_mode_o` on the next clock, and a `resume_i` pulse clears it. While `dbg_mode_o` is high, neither `dmi_req_o` nor `stall_req_o` is raised.
- R7: `susp_en_o` is high exactly when bit 7 is set and `dbg_mode_o` is high.
- R8: A `ts_fault_i` pulse goes out on `exc_pass_o` when bit 6 is clear or when in debug mode. With bit 6 set and outside debug mode, it raises the interrupt and `exc_pass_o` stays low.
- R9: With bit 5 set, `cache_dis_o` and `nowt_o` pulse for one cycle, in the first cycle that `dbg_mode_o` is high. With bit 5 clear, they stay low.
- R10: With bit 4 set, an `icebp_i` pulse outside debug mode raises the interrupt. With bit 4 clear, it has no effect.
- R11: A `dbg_exc_i` pulse goes out on `exc_pass_o` unless bit 3 is set outside debug mode, in which case it raises the interrupt instead.
- R12: With bit 2 set, an `ext_dbg_i` pulse outside debug mode raises the interrupt. In debug mode, or with bit 2 clear, it is ignored.
- R13: Several enabled events in one cycle produce a single `dmi_req_o` pulse, and `dmi_req_o` and `stall_req_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel_i | input | 1 | Control register selected |
| cfg_we_i | input | 1 | Write enable (read when low) |
| cfg_wdata_i | input | 64 | Write data |
| cfg_rdata_o | output | 64 | Read data, one cycle after a read |
| retire_i | input | 1 | Instruction completed successfully |
| icebp_i | input | 1 | ICEBP opcode executed |
| dbg_exc_i | input | 1 | Ordinary debug exception condition |
| ts_fault_i | input | 1 | Task-switch debug fault |
| ext_dbg_i | input | 1 | External debug pin event |
| resume_i | input | 1 | Return from debug mode |
| dmi_req_o | output | 1 | Debug management interrupt request |
| stall_req_o | output | 1 | Debug stall request |
| exc_pass_o | output | 1 | Event passed on as a normal debug exception |
| susp_en_o | output | 1 | Suspend enable during debug mode |
| dbg_mode_o | output | 1 | Debug mode flag |
| cache_dis_o | output | 1 | Request to set cache-disable on entry |
| nowt_o | output | 1 | Request to set no-write-through on entry |

## Verification
The bench goes after events that arrive while already in debug mode. A design that forgets the mode gate would raise a second interrupt. It would also swallow a task-switch fault that ought to pass through, or react to the external pin. The stall bit is tested with both stepping and a replaced debug exception. A wrong priority would show up as an interrupt, or as a leaked exception pass-through. Simultaneous sources are checked for a single request with no pass-through. Reserved bits are checked for exact read-back. The cache pulse is checked for landing in the entry cycle only, not the cycle after and not when the bit is clear.

// File: rtl/dbg_route_pkg.sv
package dbg_route_pkg;
  parameter int CTRL_W = 64;

  localparam int BIT_STEP  = 9;
  localparam int BIT_STALL = 8;
  localparam int BIT_SUSP  = 7;
  localparam int BIT_TSW   = 6;
  localparam int BIT_CACHE = 5;
  localparam int BIT_ICE   = 4;
  localparam int BIT_DEXC  = 3;
  localparam int BIT_PIN   = 2;

  localparam int NUM_SRC = 5;

  typedef struct packed {
    logic step;
    logic stall;
    logic susp;
    logic tsw;
    logic cache;
    logic ice;
    logic dexc;
    logic pin;
  } ctrl_fields_t;

  typedef enum logic [2:0] {
    SRC_STEP = 3'd0,
    SRC_ICE  = 3'd1,
    SRC_DEXC = 3'd2,
    SRC_TSW  = 3'd3,
    SRC_PIN  = 3'd4
  } src_idx_e;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_route_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] ctrl_o
);
  logic [W-1:0] ctrl_q;
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rd_q   <= '0;
    end else if (sel_i) begin
      if (we_i) ctrl_q <= wdata_i;
      else      rd_q   <= ctrl_q;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rd_q;
endmodule

// File: rtl/dbg_event_router.sv
module dbg_event_router
  import dbg_route_pkg::*;
(
  input  ctrl_fields_t cf_i,
  input  logic         in_dbg_i,
  input  logic         retire_i,
  input  logic         icebp_i,
  input  logic         dbg_exc_i,
  input  logic         ts_fault_i,
  input  logic         ext_dbg_i,
  output logic         dmi_o,
  output logic         stall_o,
  output logic         exc_pass_o
);
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] routed;
  logic               any_hit;

  always_comb begin
    evt = '0;
    en  = '0;
    evt[SRC_STEP] = retire_i;    en[SRC_STEP] = cf_i.step;
    evt[SRC_ICE]  = icebp_i;     en[SRC_ICE]  = cf_i.ice;
    evt[SRC_DEXC] = dbg_exc_i;   en[SRC_DEXC] = cf_i.dexc;
    evt[SRC_TSW]  = ts_fault_i;  en[SRC_TSW]  = cf_i.tsw;
    evt[SRC_PIN]  = ext_dbg_i;   en[SRC_PIN]  = cf_i.pin;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign routed[g] = evt[g] & en[g] & ~in_dbg_i;
  end

  assign any_hit = |routed;
  assign dmi_o   = any_hit & ~cf_i.stall;
  assign stall_o = any_hit &  cf_i.stall;

  assign exc_pass_o = (dbg_exc_i  & ~routed[SRC_DEXC]) |
                      (ts_fault_i & ~routed[SRC_TSW]);
endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl
  import dbg_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dmi_i,
  input  logic resume_i,
  input  logic susp_bit_i,
  input  logic cache_bit_i,
  output logic in_dbg_o,
  output logic susp_o,
  output logic cache_dis_o,
  output logic nowt_o
);
  logic in_dbg_q;
  logic entry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_dbg_q <= 1'b0;
      entry_q  <= 1'b0;
    end else begin
      entry_q <= dmi_i & ~in_dbg_q;
      if (dmi_i)         in_dbg_q <= 1'b1;
      else if (resume_i) in_dbg_q <= 1'b0;
    end
  end

  assign in_dbg_o    = in_dbg_q;
  assign susp_o      = in_dbg_q & susp_bit_i;
  assign cache_dis_o = entry_q & cache_bit_i;
  assign nowt_o      = entry_q & cache_bit_i;
endmodule

// File: rtl/dbg_route_top.sv
module dbg_route_top
  import dbg_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  input  logic              retire_i,
  input  logic              icebp_i,
  input  logic              dbg_exc_i,
  input  logic              ts_fault_i,
  input  logic              ext_dbg_i,
  input  logic              resume_i,
  output logic              dmi_req_o,
  output logic              stall_req_o,
  output logic              exc_pass_o,
  output logic              susp_en_o,
  output logic              dbg_mode_o,
  output logic              cache_dis_o,
  output logic              nowt_o
);
  logic [CTRL_W-1:0] ctrl_w;
  ctrl_fields_t      cf;
  logic              in_dbg;
  logic              dmi;

  dbg_ctrl_reg #(.W(CTRL_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .sel_i(cfg_sel_i), .we_i(cfg_we_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .ctrl_o(ctrl_w)
  );

  assign cf = '{step:  ctrl_w[BIT_STEP],  stall: ctrl_w[BIT_STALL],
                susp:  ctrl_w[BIT_SUSP],  tsw:   ctrl_w[BIT_TSW],
                cache: ctrl_w[BIT_CACHE], ice:   ctrl_w[BIT_ICE],
                dexc:  ctrl_w[BIT_DEXC],  pin:   ctrl_w[BIT_PIN]};

  dbg_event_router u_route (
    .cf_i(cf), .in_dbg_i(in_dbg), .retire_i(retire_i), .icebp_i(icebp_i),
    .dbg_exc_i(dbg_exc_i), .ts_fault_i(ts_fault_i), .ext_dbg_i(ext_dbg_i),
    .dmi_o(dmi), .stall_o(stall_req_o), .exc_pass_o(exc_pass_o)
  );

  dbg_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .dmi_i(dmi), .resume_i(resume_i),
    .susp_bit_i(cf.susp), .cache_bit_i(cf.cache), .in_dbg_o(in_dbg),
    .susp_o(susp_en_o), .cache_dis_o(cache_dis_o), .nowt_o(nowt_o)
  );

  assign dmi_req_o  = dmi;
  assign dbg_mode_o = in_dbg;
endmodule

// File: rtl/dbg_route_chk.sv
module dbg_route_chk (
  input logic clk,
  input logic rst_n,
  input logic dmi_req_o,
  input logic stall_req_o,
  input logic dbg_mode_o,
  input logic susp_en_o,
  input logic cache_dis_o,
  input logic nowt_o,
  input logic resume_i,
  input logic ext_dbg_i
);
  assert_single_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmi_req_o && stall_req_o));

  assert_mode_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req_o |=> dbg_mode_o);

  assert_quiet_in_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode_o |-> (!dmi_req_o && !stall_req_o));

  assert_resume_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && resume_i) |=> !dbg_mode_o);

  assert_susp_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    susp_en_o |-> dbg_mode_o);

  assert_cache_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cache_dis_o |-> (dbg_mode_o && $rose(dbg_mode_o) && nowt_o));

  assert_pin_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && ext_dbg_i) |-> !dmi_req_o);
endmodule

bind dbg_route_top dbg_route_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dmi_req_o(dmi_req_o), .stall_req_o(stall_req_o),
  .dbg_mode_o(dbg_mode_o), .susp_en_o(susp_en_o), .cache_dis_o(cache_dis_o),
  .nowt_o(nowt_o), .resume_i(resume_i), .ext_dbg_i(ext_dbg_i)
);

// File: tb/dbg_route_top_tb_top.sv
module dbg_route_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 0, cfg_we = 0;
  logic [63:0] cfg_wdata = '0, cfg_rdata;
  logic retire = 0, icebp = 0, dexc = 0, tsf = 0, ext = 0, resume = 0;
  logic dmi, stall, excp, susp, mode, cdis, nowt;
  logic s_dmi, s_stall, s_exc;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dbg_route_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel_i(cfg_sel), .cfg_we_i(cfg_we),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .retire_i(retire),
    .icebp_i(icebp), .dbg_exc_i(dexc), .ts_fault_i(tsf), .ext_dbg_i(ext),
    .resume_i(resume), .dmi_req_o(dmi), .stall_req_o(stall),
    .exc_pass_o(excp), .susp_en_o(susp), .dbg_mode_o(mode),
    .cache_dis_o(cdis), .nowt_o(nowt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] v);
    @(negedge clk); cfg_sel = 1; cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_sel = 0; cfg_we = 0;
  endtask

  task automatic rd(output logic [63:0] v);
    @(negedge clk); cfg_sel = 1; cfg_we = 0;
    @(negedge clk); cfg_sel = 0; #1 v = cfg_rdata;
  endtask

  // drive one cycle of events starting at a negedge, sample outputs mid-cycle
  task automatic ev(input logic r, input logic i, input logic d, input logic t, input logic e);
    @(negedge clk); retire = r; icebp = i; dexc = d; tsf = t; ext = e;
    #1 s_dmi = dmi; s_stall = stall; s_exc = excp;
    @(negedge clk); retire = 0; icebp = 0; dexc = 0; tsf = 0; ext = 0;
    #1;
  endtask

  task automatic leave();
    @(negedge clk); resume = 1;
    @(negedge clk); resume = 0; #1;
    chk("R6 resume clears mode", mode, 0);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    #1 chk("R1 mode", mode, 0);
    chk("R1 reqs", {dmi, stall, excp, susp, cdis, nowt}, 0);
    rd(v); chk("R1 reg zero", v, 0);
  endtask

  task automatic t_regrw();
    logic [63:0] v;
    wr(64'hA5C3_0F1E_8765_4C03); rd(v);
    chk("R2 readback", v, 64'hA5C3_0F1E_8765_4C03);
    wr(64'hFFFF_FFFF_FFFF_FC00); rd(v);
    chk("R2 reserved bits", v, 64'hFFFF_FFFF_FFFF_FC00);
    wr(0);
  endtask

  task automatic t_step();
    wr(64'h200); ev(1,0,0,0,0);
    chk("R3 step dmi", {s_dmi, s_stall}, 2'b10);
    chk("R6 mode set", mode, 1);
    ev(1,0,0,0,0); chk("R6 no dmi in mode", {s_dmi, s_stall}, 2'b00);
    leave();
  endtask

  task automatic t_stall();
    wr(64'h300); ev(1,0,0,0,0);
    chk("R4 step stall", {s_dmi, s_stall}, 2'b01);
    chk("R4 no mode", mode, 0);
    wr(64'h108); ev(0,0,1,0,0);
    chk("R5 dexc stall", {s_dmi, s_stall, s_exc}, 3'b010);
    chk("R5 no mode", mode, 0);
  endtask

  task automatic t_icebp();
    wr(64'h0); ev(0,1,0,0,0);
    chk("R10 disabled", {s_dmi, s_stall, s_exc}, 3'b000);
    chk("R10 disabled mode", mode, 0);
    wr(64'h10); ev(0,1,0,0,0);
    chk("R10 enabled", s_dmi, 1);
    leave();
  endtask

  task automatic t_dexc();
    wr(64'h0); ev(0,0,1,0,0);
    chk("R11 pass", {s_dmi, s_exc}, 2'b01);
    wr(64'h8); ev(0,0,1,0,0);
    chk("R11 replaced", {s_dmi, s_exc}, 2'b10);
    ev(0,0,1,0,0);
    chk("R11 pass in mode", {s_dmi, s_exc}, 2'b01);
    leave();
  endtask

  task automatic t_tsw();
    wr(64'h0); ev(0,0,0,1,0);
    chk("R8 pass", {s_dmi, s_exc}, 2'b01);
    wr(64'h40); ev(0,0,0,1,0);
    chk("R8 dmi", {s_dmi, s_exc}, 2'b10);
    ev(0,0,0,1,0);
    chk("R8 pass in mode", {s_dmi, s_exc}, 2'b01);
    leave();
  endtask

  task automatic t_pin();
    wr(64'h0); ev(0,0,0,0,1);
    chk("R12 disabled", {s_dmi, mode}, 2'b00);
    wr(64'h4); ev(0,0,0,0,1);
    chk("R12 enabled", s_dmi, 1);
    ev(0,0,0,0,1);
    chk("R12 ignored in mode", {s_dmi, s_stall}, 2'b00);
    leave();
  endtask

  task automatic t_susp_cache();
    wr(64'hA4);
    chk("R7 susp outside mode", susp, 0);
    @(negedge clk); ext = 1;
    @(negedge clk); ext = 0; #1;
    chk("R9 entry pulse", {mode, cdis, nowt}, 3'b111);
    chk("R7 susp in mode", susp, 1);
    @(negedge clk); #1;
    chk("R9 pulse ends", {cdis, nowt}, 2'b00);
    leave();
    chk("R7 susp after exit", susp, 0);
    wr(64'h4);
    @(negedge clk); ext = 1;
    @(negedge clk); ext = 0; #1;
    chk("R9 bit clear no pulse", {mode, cdis, nowt, susp}, 4'b1000);
    leave();
  endtask

  task automatic t_multi();
    int n = 0;
    wr(64'h21C);
    @(negedge clk); retire = 1; icebp = 1; dexc = 1; ext = 1;
    #1 chk("R13 one dmi", {dmi, stall, excp}, 3'b100);
    @(negedge clk); retire = 0; icebp = 0; dexc = 0; ext = 0;
    for (int k = 0; k < 3; k++) begin
      #1 if (dmi) n++;
      @(negedge clk);
    end
    chk("R13 no repeat", n, 0);
    leave();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_regrw(); t_step(); t_stall(); t_icebp();
    t_dexc(); t_tsw(); t_pin(); t_susp_cache(); t_multi();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule